// File: doc/BRIEF.md
# CRC-Hash Filtered Keystream Generator

This block produces a pseudorandom keystream, one bit per enabled clock, for a binary additive stream cipher. A maximal-length linear feedback shift register emits one bit per step. That bit is fed serially into a polynomial division register, which works like a serial CRC. A nonlinear Boolean function of the division register then forms the keystream bit. The combining XOR with the message is done outside the block.

A key is written once with `key_load`. The low bits seed the shift register and the high bits preset the division register. A `start` pulse then begins generation, and `enable` paces it. After the combined period of (2^m-1)(2^n-1) steps, the block spends one enabled cycle reloading both registers from the stored key, so the stream starts again from its first bit and never runs into an uncontrolled wrap.

Top module: `crc_filter_keygen`

## Requirements
- R1: While reset is asserted and after it is released, `ks_valid` and `ks_bit` are 0 until generation is started.
- R2: A `key_load` pulse stores `key_in` and loads both registers from it. Bits [8:0] seed the shift register and bits [10:9] preset the division register. The block then stays idle, with `ks_valid` low, until `start`.
- R3: A `start` pulse reloads both registers from the stored key and clears the step counter, with `ks_valid` low in the following cycle. From then on, every cycle with `enable` high yields one valid bit in the next cycle.
- R4: The shift register state s[8:0] steps to {s[0]^s[4], s[8:1]}, which follows Q(x)=x^9+x^4+1. The bit sent to the division stage is s[0] before the step.
- R5: The division register c[1:0] takes the input bit d. With f = c[1]^d, it steps to {c[0]^f, f}, which is reduction modulo x^2+x+1.
- R6: The keystream bit is (c[0] AND c[1]) XOR c[1], computed on the division register value after the step.
- R7: A cycle with `enable` low changes no state and gives `ks_valid` 0 in the next cycle. The stream then resumes with the bit that would have come next.
- R8: After 1533 valid bits since the last reload, the next enabled cycle reloads from the key with `ks_valid` low. The bits that follow repeat the stream from its first bit.
- R9: A shift register seed of all zeros is replaced by 9'b000000001.
- R10: `ks_bit` is 0 in every cycle where `ks_valid` is 0.
- R11: When `key_load` and `start` are high in the same cycle, `key_load` wins and the block stays idle. A `key_load` during generation stops the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | Store `key_in` and load registers; idle afterwards |
| key_in | input | 11 | Key: [8:0] shift register seed, [10:9] division preset |
| start | input | 1 | Reload from stored key and begin generation |
| enable | input | 1 | Advance the generator one step this cycle |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | `ks_bit` holds a new keystream bit |

## Verification
On every cycle, the assertions check the following:
- the output stays quiet while it is invalid;
- valid bits appear only one cycle after a step;
- the state holds when the block does nothing;
- the shift register shifts and never becomes zero;
- the step counter stays within its bound and clears at the wrap.

The actual bit values need the bench's scenarios. These are the recurrence, the division, the filter, the zero-seed substitution, the exact repeat of the stream after reseeding and the priority between loading and starting. The bench checks them against its own step-by-step model of the stream.

// File: rtl/ksg_pkg.sv
`timescale 1ns/1ps
package ksg_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_STEP   = 2'd1,
    ACT_RELOAD = 2'd2
  } ksg_act_e;

  // number of steps before the joint state of both registers repeats
  function automatic int unsigned combined_period(input int unsigned m, input int unsigned n);
    return ((32'd1 << m) - 32'd1) * ((32'd1 << n) - 32'd1);
  endfunction

endpackage

// File: rtl/ksg_sequencer.sv
`timescale 1ns/1ps
module ksg_sequencer #(
  parameter int unsigned PERIOD = 1533,
  parameter int unsigned CNT_W  = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 key_load,
  input  logic                 start,
  input  logic                 enable,
  output ksg_pkg::ksg_act_e    act,
  output logic                 wrap_evt,
  output logic [CNT_W-1:0]     step_cnt
);
  import ksg_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD);

  logic running;
  logic at_end;

  assign at_end   = (step_cnt == LAST);
  assign wrap_evt = running && enable && at_end && !key_load && !start;

  always_comb begin
    if (key_load || start)      act = ACT_RELOAD;
    else if (running && enable) act = at_end ? ACT_RELOAD : ACT_STEP;
    else                        act = ACT_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      step_cnt <= '0;
    end else begin
      if (key_load)   running <= 1'b0;
      else if (start) running <= 1'b1;
      case (act)
        ACT_RELOAD: step_cnt <= '0;
        ACT_STEP:   step_cnt <= step_cnt + 1'b1;
        default:    step_cnt <= step_cnt;
      endcase
    end
  end
endmodule

// File: rtl/ksg_lfsr.sv
`timescale 1ns/1ps
module ksg_lfsr #(
  parameter int unsigned          LEN      = 9,
  parameter logic [LEN-1:0]       TAPS     = 9'h011,
  parameter logic [LEN-1:0]       ZERO_SUB = 9'h001
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [LEN-1:0] seed,
  output logic [LEN-1:0] state,
  output logic           out_bit
);
  function automatic logic [LEN-1:0] lfsr_next(input logic [LEN-1:0] s);
    logic fb;
    fb = ^(s & TAPS);
    return {fb, s[LEN-1:1]};
  endfunction

  function automatic logic [LEN-1:0] safe_seed(input logic [LEN-1:0] s);
    return (s == '0) ? ZERO_SUB : s;
  endfunction

  assign out_bit = state[0];

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= ZERO_SUB;
    else if (load) state <= safe_seed(seed);
    else if (step) state <= lfsr_next(state);
  end
endmodule

// File: rtl/ksg_divider.sv
`timescale 1ns/1ps
module ksg_divider #(
  parameter int unsigned    DEG  = 2,
  parameter logic [DEG-1:0] POLY = 2'b11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [DEG-1:0] init,
  input  logic           din,
  output logic [DEG-1:0] state,
  output logic [DEG-1:0] next_state
);
  // one serial step of division by x^DEG + POLY
  function automatic logic [DEG-1:0] div_next(input logic [DEG-1:0] c, input logic d);
    logic fb;
    fb = c[DEG-1] ^ d;
    return (c << 1) ^ (fb ? POLY : '0);
  endfunction

  assign next_state = div_next(state, din);

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= '0;
    else if (load) state <= init;
    else if (step) state <= next_state;
  end
endmodule

// File: rtl/ksg_filter.sv
`timescale 1ns/1ps
module ksg_filter #(
  parameter int unsigned DEG = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic [DEG-1:0] div_val,
  output logic           ks_bit,
  output logic           ks_valid
);
  // one product term plus parity of the upper taps
  function automatic logic filt(input logic [DEG-1:0] c);
    return (c[0] & c[1]) ^ (^c[DEG-1:1]);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ks_bit   <= 1'b0;
      ks_valid <= 1'b0;
    end else begin
      ks_valid <= step;
      ks_bit   <= step ? filt(div_val) : 1'b0;
    end
  end
endmodule

// File: rtl/crc_filter_keygen.sv
`timescale 1ns/1ps
module crc_filter_keygen #(
  parameter int unsigned             LFSR_LEN  = 9,
  parameter logic [LFSR_LEN-1:0]     LFSR_TAPS = 9'h011,
  parameter logic [LFSR_LEN-1:0]     ZERO_SUB  = 9'h001,
  parameter int unsigned             DIV_DEG   = 2,
  parameter logic [DIV_DEG-1:0]      DIV_POLY  = 2'b11,
  localparam int unsigned            KEY_W     = LFSR_LEN + DIV_DEG,
  localparam int unsigned            PERIOD    = ksg_pkg::combined_period(LFSR_LEN, DIV_DEG),
  localparam int unsigned            CNT_W     = $clog2(PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_load,
  input  logic [KEY_W-1:0] key_in,
  input  logic             start,
  input  logic             enable,
  output logic             ks_bit,
  output logic             ks_valid
);
  import ksg_pkg::*;

  ksg_act_e             act;
  logic                 step_evt;
  logic                 reload_evt;
  logic                 wrap_evt;
  logic [CNT_W-1:0]     step_cnt;
  logic [KEY_W-1:0]     key_q;
  logic [KEY_W-1:0]     key_src;
  logic [LFSR_LEN-1:0]  lfsr_state;
  logic                 lfsr_bit;
  logic [DIV_DEG-1:0]   crc_state;
  logic [DIV_DEG-1:0]   crc_next;

  assign step_evt   = (act == ACT_STEP);
  assign reload_evt = (act == ACT_RELOAD);
  assign key_src    = key_load ? key_in : key_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        key_q <= '0;
    else if (key_load) key_q <= key_in;
  end

  ksg_sequencer #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .start(start), .enable(enable),
    .act(act), .wrap_evt(wrap_evt), .step_cnt(step_cnt)
  );

  ksg_lfsr #(.LEN(LFSR_LEN), .TAPS(LFSR_TAPS), .ZERO_SUB(ZERO_SUB)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(reload_evt), .step(step_evt),
    .seed(key_src[LFSR_LEN-1:0]), .state(lfsr_state), .out_bit(lfsr_bit)
  );

  ksg_divider #(.DEG(DIV_DEG), .POLY(DIV_POLY)) u_div (
    .clk(clk), .rst_n(rst_n), .load(reload_evt), .step(step_evt),
    .init(key_src[KEY_W-1:LFSR_LEN]), .din(lfsr_bit),
    .state(crc_state), .next_state(crc_next)
  );

  ksg_filter #(.DEG(DIV_DEG)) u_filt (
    .clk(clk), .rst_n(rst_n), .step(step_evt), .div_val(crc_next),
    .ks_bit(ks_bit), .ks_valid(ks_valid)
  );
endmodule

// File: rtl/crc_filter_keygen_chk.sv
`timescale 1ns/1ps
module crc_filter_keygen_chk #(
  parameter int unsigned LFSR_LEN = 9,
  parameter int unsigned DIV_DEG  = 2,
  parameter int unsigned PERIOD   = 1533,
  parameter int unsigned CNT_W    = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                key_load,
  input logic                start,
  input logic                enable,
  input logic                ks_bit,
  input logic                ks_valid,
  input logic                step_evt,
  input logic                reload_evt,
  input logic                wrap_evt,
  input logic [CNT_W-1:0]    step_cnt,
  input logic [LFSR_LEN-1:0] lfsr_state,
  input logic [DIV_DEG-1:0]  crc_state
);
  AST_QUIET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ks_valid |-> !ks_bit); // R10
  AST_STEP_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> ks_valid); // R3
  AST_VALID_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step_evt |=> !ks_valid); // R3
  AST_START_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ks_valid); // R3
  AST_LOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |=> !ks_valid); // R2
  AST_ENABLE_LOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ks_valid); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !reload_evt) |=> ($stable(lfsr_state) && $stable(crc_state))); // R7
  AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (lfsr_state[LFSR_LEN-2:0] == $past(lfsr_state[LFSR_LEN-1:1]))); // R4
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != '0); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt <= CNT_W'(PERIOD)); // R8
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (!ks_valid && step_cnt == '0)); // R8
endmodule

bind crc_filter_keygen crc_filter_keygen_chk #(
  .LFSR_LEN(LFSR_LEN), .DIV_DEG(DIV_DEG), .PERIOD(PERIOD), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .key_load(key_load), .start(start), .enable(enable),
  .ks_bit(ks_bit), .ks_valid(ks_valid), .step_evt(step_evt), .reload_evt(reload_evt),
  .wrap_evt(wrap_evt), .step_cnt(step_cnt), .lfsr_state(lfsr_state), .crc_state(crc_state)
);

// File: tb/crc_filter_keygen_test.sv
`timescale 1ns/1ps
module crc_filter_keygen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_load = 1'b0;
  logic [10:0] key_in = '0;
  logic        start = 1'b0;
  logic        enable = 1'b0;
  logic        ks_bit;
  logic        ks_valid;

  int checks = 0;
  int errors = 0;

  // bench model of the stream, written from the requirements
  logic [8:0]  m_s;
  logic [1:0]  m_c;
  logic [10:0] m_key = '0;
  bit          m_run = 1'b0;
  int          m_cnt = 0;
  logic        last_b;

  always #5 clk = ~clk;

  crc_filter_keygen uut (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
    .start(start), .enable(enable), .ks_bit(ks_bit), .ks_valid(ks_valid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic m_reload();
    m_s   = (m_key[8:0] == 9'd0) ? 9'd1 : m_key[8:0];   // R9 substitution
    m_c   = m_key[10:9];
    m_cnt = 0;
  endtask

  // one clock with enable = en; checks the output of that edge
  task automatic cyc(input bit en, input string req);
    logic d, f, exp_v, exp_b;
    enable = en;
    @(negedge clk);
    exp_v = 1'b0;
    exp_b = 1'b0;
    if (m_run && en) begin
      if (m_cnt == 1533) begin
        m_reload();
      end else begin
        d     = m_s[0];
        m_s   = {m_s[0] ^ m_s[4], m_s[8:1]};
        f     = m_c[1] ^ d;
        m_c   = {m_c[0] ^ f, f};
        exp_b = m_c[1] & ~m_c[0];
        exp_v = 1'b1;
        m_cnt++;
      end
    end
    last_b = ks_bit;
    chk(req, "ks_valid", int'(ks_valid), int'(exp_v));
    chk(exp_v ? req : "R10", "ks_bit", int'(ks_bit), int'(exp_b));
  endtask

  task automatic do_load(input logic [10:0] k);
    key_load = 1'b1; key_in = k; enable = 1'b1;
    @(negedge clk);
    key_load = 1'b0;
    m_key = k; m_run = 1'b0; m_reload();
    chk("R2", "ks_valid after load", int'(ks_valid), 0);
  endtask

  task automatic do_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m_run = 1'b1; m_reload();
    chk("R3", "ks_valid after start", int'(ks_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1", "ks_valid in reset", int'(ks_valid), 0);
    chk("R1", "ks_bit in reset", int'(ks_bit), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b1, "R1");
  endtask

  task automatic t_load_idle();
    do_load(11'b10_110100011);
    for (int i = 0; i < 6; i++) cyc(1'b1, "R2");
  endtask

  task automatic t_stream();
    do_start();
    for (int i = 0; i < 60; i++) cyc(1'b1, "R6");
    do_load(11'b01_000101101);
    do_start();
    for (int i = 0; i < 60; i++) cyc(1'b1, "R5");
    do_load(11'b11_111111111);
    do_start();
    for (int i = 0; i < 40; i++) cyc(1'b1, "R4");
  endtask

  task automatic t_enable_gaps();
    do_load(11'b00_011001110);
    do_start();
    for (int i = 0; i < 48; i++) cyc((i % 3 != 1) && (i % 7 != 5), "R7");
    for (int i = 0; i < 5; i++) cyc(1'b0, "R7");
    for (int i = 0; i < 10; i++) cyc(1'b1, "R7");
  endtask

  task automatic t_zero_seed();
    do_load(11'b10_000000000);
    do_start();
    for (int i = 0; i < 40; i++) cyc(1'b1, "R9");
  endtask

  task automatic t_reseed();
    logic first [16];
    do_load(11'b01_100111001);
    do_start();
    for (int i = 0; i < 1533; i++) begin
      cyc(i % 97 != 50, "R8");
      if (i < 16) first[i] = last_b;
      if (i % 97 == 50) cyc(1'b1, "R8");
    end
    cyc(1'b1, "R8");   // reload cycle: valid low
    chk("R8", "valid in reload cycle", int'(ks_valid), 0);
    for (int i = 0; i < 16; i++) begin
      cyc(1'b1, "R8");
      chk("R8", "repeat of first bits", int'(last_b), int'(first[i]));
    end
  endtask

  task automatic t_priority();
    key_load = 1'b1; start = 1'b1; key_in = 11'b11_010101010; enable = 1'b1;
    @(negedge clk);
    key_load = 1'b0; start = 1'b0;
    m_key = 11'b11_010101010; m_run = 1'b0; m_reload();
    chk("R11", "valid after load+start", int'(ks_valid), 0);
    for (int i = 0; i < 4; i++) cyc(1'b1, "R11");
    do_start();
    for (int i = 0; i < 8; i++) cyc(1'b1, "R11");
    do_load(11'b00_001110001);
    for (int i = 0; i < 4; i++) cyc(1'b1, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_load_idle();
    t_stream();
    t_enable_gaps();
    t_zero_seed();
    t_reseed();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule